// File: doc/BRIEF.md
# Signed Integer Divider with Register Interface

This block divides a signed numerator by a signed denominator and returns a quotient and a remainder through registers on a simple word bus. Software writes the operands and a two-bit mode, reads a busy flag until it clears, then reads the results. Any write to the control word or to an operand word starts a new division. A write that arrives while a division is still running abandons it and starts over with the current register contents.

The mode picks the effective operand widths. In the narrowest mode both operands are 32-bit values sign-extended to 64 bits. In the mixed modes a full 64-bit numerator is divided by a sign-extended 32-bit denominator. In the wide mode both operands are used at full width. The datapath is a restoring divider that works on magnitudes and produces one quotient bit per clock. A sign fix-up is applied when the last bit is produced. A zero denominator and the single overflowing quotient (most negative value divided by minus one) skip the datapath. They set an error flag and write fixed results one cycle after the start.

Each 64-bit register takes two bus words, with the low half at the lower word address.

Top module: `mm_sdiv`

## Requirements
- R1: Word map: address 0 is control, with mode in bits [1:0], error in bit 14 and busy in bit 15; addresses 1/2 are the numerator low/high halves, 3/4 the denominator, 5/6 the quotient and 7/8 the remainder. The mode reads back as written, and all other control bits read 0. After reset every word reads 0.
- R2: In mode 0 the effective numerator is bits [31:0] of the numerator register sign-extended to 64 bits. In modes 1, 2 and 3 the full 64-bit numerator is used.
- R3: In modes 0, 1 and 3 the effective denominator is bits [31:0] of the denominator register sign-extended. In mode 2 the full 64-bit denominator is used.
- R4: A write to address 0 to 4 sets busy, which reads 1 from the cycle after the write. Busy clears 65 clock edges after the write edge for an ordinary division, and 1 edge after it for the two error cases.
- R5: A zero effective denominator sets the error bit. The remainder becomes the effective numerator, and the quotient becomes 1 if that numerator is negative and 0 otherwise.
- R6: A numerator of 0x8000_0000_0000_0000 with an effective denominator of -1 sets the error bit. The quotient becomes the numerator, and the remainder keeps its previous value.
- R7: In all other cases the quotient is truncated toward zero, the remainder has the sign of the numerator (or is zero), and the error bit is cleared.
- R8: A write that starts a division while busy is set restarts the division. The results reflect the operands after the last write, and busy clears 65 edges after that write.
- R9: Writes to the result words or to addresses 9 and above change nothing and start nothing. Reads of addresses 9 and above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | BW | Write data |
| rd_addr | input | AW | Word address of the read |
| rd_data | output | BW | Read data, combinational from rd_addr |

## Verification
A wrong bit-position counter or a lost sign latch shows up at the result words when busy clears. It appears as a quotient or remainder that disagrees with the truncating model, or as busy clearing earlier or later than the 65th edge. An error flag decoded from the wrong mode shows one edge after the start, since the special cases finish at once. A restart that fails to reload leaves busy running out on the old count, which is visible as a short latency measured from the second write.

// File: rtl/mm_sdiv_pkg.sv
package mm_sdiv_pkg;
   typedef enum logic [1:0] {
      MODE_NARROW = 2'd0,
      MODE_MIXED  = 2'd1,
      MODE_WIDE   = 2'd2,
      MODE_MIXED3 = 2'd3
   } div_mode_e;

   localparam int REG_CTRL  = 0;
   localparam int REG_NUM   = 1;
   localparam int REG_DEN   = 3;
   localparam int REG_QUO   = 5;
   localparam int REG_REM   = 7;
   localparam int REG_COUNT = 9;

   localparam int BUSY_BIT  = 15;
   localparam int ERR_BIT   = 14;
   localparam int CTRL_W    = 16;
endpackage

// File: rtl/mm_sdiv_prep.sv
module mm_sdiv_prep
   import mm_sdiv_pkg::*;
#(
   parameter int DW = 64,
   parameter int HW = 32
) (
   input  logic [1:0]    mode,
   input  logic [DW-1:0] num_raw,
   input  logic [DW-1:0] den_raw,
   output logic [DW-1:0] num_eff,
   output logic [DW-1:0] den_eff,
   output logic [DW-1:0] num_mag,
   output logic [DW-1:0] den_mag,
   output logic          num_neg,
   output logic          den_neg,
   output logic          den_zero,
   output logic          ovf
);
   localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

   logic [DW-1:0] num_sx, den_sx;

   assign num_sx = {{(DW-HW){num_raw[HW-1]}}, num_raw[HW-1:0]};
   assign den_sx = {{(DW-HW){den_raw[HW-1]}}, den_raw[HW-1:0]};

   always_comb begin
      num_eff = (div_mode_e'(mode) == MODE_NARROW) ? num_sx : num_raw;
      den_eff = (div_mode_e'(mode) == MODE_WIDE)   ? den_raw : den_sx;
   end

   assign num_neg  = num_eff[DW-1];
   assign den_neg  = den_eff[DW-1];
   assign num_mag  = num_neg ? (DW'(0) - num_eff) : num_eff;
   assign den_mag  = den_neg ? (DW'(0) - den_eff) : den_eff;
   assign den_zero = (den_eff == '0);
   assign ovf      = (num_eff == MOST_NEG) && (den_eff == '1);
endmodule

// File: rtl/mm_sdiv_core.sv
module mm_sdiv_core #(
   parameter int DW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          go,
   input  logic [DW-1:0] dvd,
   input  logic [DW-1:0] dvs,
   output logic          run,
   output logic          done,
   output logic [DW-1:0] q_next,
   output logic [DW-1:0] r_next
);
   localparam int CW = $clog2(DW + 1);

   logic          run_q;
   logic [CW-1:0] cnt_q;
   logic [DW-1:0] quo_q, rem_q, dvs_q;
   logic [DW:0]   trial, diff;
   logic          fits;

   assign trial  = {rem_q, quo_q[DW-1]};
   assign diff   = trial - {1'b0, dvs_q};
   assign fits   = ~diff[DW];
   assign q_next = {quo_q[DW-2:0], fits};
   assign r_next = fits ? diff[DW-1:0] : trial[DW-1:0];
   assign run    = run_q;
   assign done   = run_q && (cnt_q == CW'(1)) && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         quo_q <= '0;
         rem_q <= '0;
         dvs_q <= '0;
      end else if (load) begin
         run_q <= go;
         cnt_q <= CW'(DW);
         quo_q <= dvd;
         rem_q <= '0;
         dvs_q <= dvs;
      end else if (run_q) begin
         quo_q <= q_next;
         rem_q <= r_next;
         cnt_q <= cnt_q - CW'(1);
         if (cnt_q == CW'(1)) run_q <= 1'b0;
      end
   end
endmodule

// File: rtl/mm_sdiv_fix.sv
module mm_sdiv_fix #(
   parameter int DW = 64
) (
   input  logic [DW-1:0] q_mag,
   input  logic [DW-1:0] r_mag,
   input  logic          q_neg,
   input  logic          r_neg,
   output logic [DW-1:0] quo,
   output logic [DW-1:0] rem
);
   assign quo = q_neg ? (DW'(0) - q_mag) : q_mag;
   assign rem = r_neg ? (DW'(0) - r_mag) : r_mag;
endmodule

// File: rtl/mm_sdiv.sv
module mm_sdiv
   import mm_sdiv_pkg::*;
#(
   parameter int DW = 64,
   parameter int BW = 32,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [BW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [BW-1:0] rd_data
);
   localparam int NW = DW / BW;

   if (DW != 2 * BW) begin : g_bad_width
      $error("mm_sdiv: DW must be twice BW");
   end
   if (BW < CTRL_W) begin : g_bad_bus
      $error("mm_sdiv: BW too narrow for the control word");
   end
   if ((1 << AW) < REG_COUNT) begin : g_bad_addr
      $error("mm_sdiv: AW too small for the register map");
   end

   logic [1:0]    mode_q;
   logic [DW-1:0] num_q, den_q, quo_q, rem_q;
   logic [DW-1:0] num_nx, den_nx;
   logic          err_q, launch_q, qneg_q, rneg_q;
   logic          start, busy;

   logic [DW-1:0] num_eff, den_eff, num_mag, den_mag;
   logic          num_neg, den_neg, den_zero, ovf;
   logic          core_run, core_done;
   logic [DW-1:0] core_q, core_r, fix_q, fix_r;

   logic [BW-1:0] words [REG_COUNT];

   assign start = wr_en && (wr_addr < AW'(REG_QUO));
   assign busy  = launch_q | core_run;

   for (genvar w = 0; w < NW; w++) begin : g_word
      assign num_nx[w*BW +: BW] = (wr_en && wr_addr == AW'(REG_NUM + w)) ?
                                  wr_data : num_q[w*BW +: BW];
      assign den_nx[w*BW +: BW] = (wr_en && wr_addr == AW'(REG_DEN + w)) ?
                                  wr_data : den_q[w*BW +: BW];
      assign words[REG_NUM + w] = num_q[w*BW +: BW];
      assign words[REG_DEN + w] = den_q[w*BW +: BW];
      assign words[REG_QUO + w] = quo_q[w*BW +: BW];
      assign words[REG_REM + w] = rem_q[w*BW +: BW];
   end

   always_comb begin
      words[REG_CTRL]           = '0;
      words[REG_CTRL][1:0]      = mode_q;
      words[REG_CTRL][ERR_BIT]  = err_q;
      words[REG_CTRL][BUSY_BIT] = busy;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < REG_COUNT; i++) begin
         if (rd_addr == AW'(i)) rd_data = words[i];
      end
   end

   mm_sdiv_prep #(.DW(DW), .HW(BW)) u_prep (
      .mode     (mode_q),
      .num_raw  (num_q),
      .den_raw  (den_q),
      .num_eff  (num_eff),
      .den_eff  (den_eff),
      .num_mag  (num_mag),
      .den_mag  (den_mag),
      .num_neg  (num_neg),
      .den_neg  (den_neg),
      .den_zero (den_zero),
      .ovf      (ovf)
   );

   mm_sdiv_core #(.DW(DW)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (launch_q),
      .go     (!(den_zero || ovf)),
      .dvd    (num_mag),
      .dvs    (den_mag),
      .run    (core_run),
      .done   (core_done),
      .q_next (core_q),
      .r_next (core_r)
   );

   mm_sdiv_fix #(.DW(DW)) u_fix (
      .q_mag (core_q),
      .r_mag (core_r),
      .q_neg (qneg_q),
      .r_neg (rneg_q),
      .quo   (fix_q),
      .rem   (fix_r)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         num_q    <= '0;
         den_q    <= '0;
         launch_q <= 1'b0;
      end else begin
         num_q    <= num_nx;
         den_q    <= den_nx;
         launch_q <= start;
         if (wr_en && wr_addr == AW'(REG_CTRL)) mode_q <= wr_data[1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q  <= '0;
         rem_q  <= '0;
         err_q  <= 1'b0;
         qneg_q <= 1'b0;
         rneg_q <= 1'b0;
      end else if (launch_q) begin
         if (den_zero) begin
            quo_q <= {{(DW-1){1'b0}}, num_neg};
            rem_q <= num_eff;
            err_q <= 1'b1;
         end else if (ovf) begin
            quo_q <= num_eff;
            err_q <= 1'b1;
         end else begin
            err_q  <= 1'b0;
            qneg_q <= num_neg ^ den_neg;
            rneg_q <= num_neg;
         end
      end else if (core_done) begin
         quo_q <= fix_q;
         rem_q <= fix_r;
      end
   end
endmodule

// File: rtl/mm_sdiv_chk.sv
module mm_sdiv_chk #(
   parameter int DW = 64,
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic          launch,
   input logic          run,
   input logic          busy,
   input logic          err,
   input logic          den_zero,
   input logic          num_neg,
   input logic [DW-1:0] num_eff,
   input logic [DW-1:0] den_mag,
   input logic [DW-1:0] quo,
   input logic [DW-1:0] rem
);
   localparam int LW = $clog2(DW + 3);

   logic          wr_start;
   logic [LW-1:0] busy_len;
   logic [DW-1:0] rem_mag;

   assign wr_start = wr_en && (wr_addr < AW'(5));
   assign rem_mag  = rem[DW-1] ? (DW'(0) - rem) : rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        busy_len <= '0;
      else if (wr_start) busy_len <= '0;
      else if (busy && busy_len != '1) busy_len <= busy_len + LW'(1);
   end

   p_busy_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> busy);

   p_busy_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_len <= LW'(DW + 1)));

   p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!launch && !run) |=> ($stable(quo) && $stable(rem) && $stable(err)));

   p_zero_den_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && den_zero) |=> (err && rem == $past(num_eff)));

   p_rem_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !err) |-> (rem == '0 || rem[DW-1] == num_neg));

   p_rem_small_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !err) |-> (rem_mag < den_mag));
endmodule

bind mm_sdiv mm_sdiv_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .launch   (launch_q),
   .run      (core_run),
   .busy     (busy),
   .err      (err_q),
   .den_zero (den_zero),
   .num_neg  (num_neg),
   .num_eff  (num_eff),
   .den_mag  (den_mag),
   .quo      (quo_q),
   .rem      (rem_q)
);

// File: tb/test_mm_sdiv.sv
`timescale 1ns/1ps
module test_mm_sdiv;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [63:0] model_rem = '0;

   always #4 clk = ~clk;

   mm_sdiv i_mm_sdiv (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic rd64(input logic [3:0] a, output logic [63:0] d);
      logic [31:0] lo, hi;
      rd(a, lo);
      rd(a + 4'd1, hi);
      d = {hi, lo};
   endtask

   function automatic logic [63:0] sx(input logic [31:0] v);
      return {{32{v[31]}}, v};
   endfunction

   function automatic void ref_div(input logic [1:0] m, input logic [63:0] n, input logic [63:0] d,
                                   input logic [63:0] old_r, output logic [63:0] q,
                                   output logic [63:0] r, output bit e, output int lat);
      longint ne, de;
      ne = (m == 2'd0) ? longint'(sx(n[31:0])) : longint'(n);
      de = (m == 2'd2) ? longint'(d) : longint'(sx(d[31:0]));
      if (de == 0) begin
         e = 1; r = ne; q = (ne < 0) ? 64'd1 : 64'd0; lat = 1;
      end else if (ne == 64'sh8000_0000_0000_0000 && de == -1) begin
         e = 1; q = ne; r = old_r; lat = 1;
      end else begin
         e = 0; q = ne / de; r = ne % de; lat = 65;
      end
   endfunction

   task automatic wait_idle(output int n);
      logic [31:0] c;
      n = 0;
      rd(4'd0, c);
      while (c[15] && n < 300) begin
         @(posedge clk);
         #1;
         n++;
         rd(4'd0, c);
      end
   endtask

   task automatic finish_check(input string tag, input logic [1:0] m, input logic [63:0] n,
                               input logic [63:0] d);
      logic [63:0] eq, er, aq, ar;
      logic [31:0] c;
      bit ee;
      int el, n_cyc;
      ref_div(m, n, d, model_rem, eq, er, ee, el);
      rd(4'd0, c);
      chk({tag, " R4 busy after start"}, 64'(c[15]), 64'd1);
      wait_idle(n_cyc);
      chk({tag, " R4 R8 latency"}, 64'(n_cyc), 64'(el));
      rd64(4'd5, aq);
      rd64(4'd7, ar);
      rd(4'd0, c);
      chk({tag, " R5 R6 R7 quotient"}, aq, eq);
      chk({tag, " R5 R6 R7 remainder"}, ar, er);
      chk({tag, " R5 R6 R7 error bit"}, 64'(c[14]), 64'(ee));
      chk({tag, " R1 mode readback"}, 64'(c[1:0]), 64'(m));
      model_rem = er;
   endtask

   task automatic run_div(input string tag, input logic [1:0] m, input logic [63:0] n,
                          input logic [63:0] d);
      wr(4'd1, n[31:0]);
      wr(4'd2, n[63:32]);
      wr(4'd3, d[31:0]);
      wr(4'd4, d[63:32]);
      wr(4'd0, {30'd0, m});
      finish_check(tag, m, n, d);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [63:0] q0, n, d;
      logic [1:0] m;
      int lat;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 R10 reset state: all words read 0
      for (int a = 0; a < 9; a++) begin
         rd(4'(a), v);
         chk("R1 reset word", 64'(v), 64'd0);
      end

      // R7 basic signs
      run_div("pos/pos", 2'd2, 64'd100, 64'd7);
      run_div("neg/pos", 2'd2, -64'sd100, 64'd7);
      run_div("pos/neg", 2'd2, 64'd100, -64'sd7);
      run_div("neg/neg", 2'd2, -64'sd100, -64'sd7);
      // R2 mode 0 ignores numerator high half, sign-extends low half
      run_div("R2 narrow", 2'd0, 64'hDEAD_BEEF_FFFF_FF9C, 64'h1234_5678_0000_0007);
      // R3 modes 1 and 3 sign-extend denominator low half; mode 2 uses full
      run_div("R3 mixed", 2'd1, 64'h0123_4567_89AB_CDEF, 64'h7777_0000_FFFF_FFFD);
      run_div("R3 mixed3", 2'd3, 64'h0123_4567_89AB_CDEF, 64'h7777_0000_0000_0010);
      run_div("R3 wide", 2'd2, 64'h0123_4567_89AB_CDEF, 64'h0000_0001_0000_0003);
      // R5 zero denominator, both numerator signs; high half ignored in mode 1
      run_div("R5 zero pos", 2'd1, 64'd12345, 64'h5555_0000_0000_0000);
      run_div("R5 zero neg", 2'd2, -64'sd9, 64'd0);
      run_div("R5 zero narrow", 2'd0, 64'h0000_0001_8000_0000, 64'd0);
      // R7 normal division clears error bit
      run_div("R7 clear err", 2'd2, 64'd1, 64'd3);
      // R6 overflow: remainder kept
      run_div("R6 ovf wide", 2'd2, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
      run_div("R6 ovf mixed", 2'd1, 64'h8000_0000_0000_0000, 64'h0000_0000_FFFF_FFFF);
      // R2: most negative 32-bit in mode 0 divides normally
      run_div("R2 min32", 2'd0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF);
      run_div("R7 min64 by 2", 2'd2, 64'h8000_0000_0000_0000, 64'd2);

      // R8 restart while busy
      wr(4'd1, 32'd1000); wr(4'd2, 32'd0); wr(4'd3, 32'd3); wr(4'd4, 32'd0);
      wr(4'd0, 32'd1);
      repeat (10) @(posedge clk);
      #1;
      wr(4'd3, 32'hFFFF_FFF9);
      finish_check("R8 restart", 2'd1, 64'd1000, 64'hFFFF_FFF9);

      // R9 writes to result words and unmapped addresses
      rd64(4'd5, q0);
      wr(4'd5, 32'hA5A5_A5A5);
      wr(4'd8, 32'h5A5A_5A5A);
      wr(4'd12, 32'hFFFF_FFFF);
      rd(4'd0, v);
      chk("R9 no start from result write", 64'(v[15]), 64'd0);
      rd64(4'd5, n);
      chk("R9 quotient unchanged", n, q0);
      rd64(4'd7, n);
      chk("R9 remainder unchanged", n, model_rem);
      rd(4'd10, v);
      chk("R9 unmapped read", 64'(v), 64'd0);
      rd(4'd0, v);
      chk("R1 ctrl upper bits zero", 64'(v[31:16]), 64'd0);

      // random mix
      for (int i = 0; i < 60; i++) begin
         m = 2'($urandom_range(0, 3));
         n = {$urandom, $urandom};
         case ($urandom_range(0, 3))
            0: d = {$urandom, $urandom};
            1: d = 64'($urandom_range(1, 50));
            2: d = -64'($urandom_range(1, 50));
            default: d = {32'($urandom), $urandom};
         endcase
         if ($urandom_range(0, 7) == 0) n = {32'd0, $urandom};
         run_div("random R7", m, n, d);
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule